// File: doc/BRIEF.md
# Full-Duplex Clocked Serial Port

This block is an 8-bit serial port for clocked links. Software, or a hardware-access engine, hands it bytes through a small register window. The port shifts each byte out on `txd` and, in the same frame, shifts a byte in from `rxd`. The port generates the bit clock and drives it on `sclk`. A one-byte holding register on each side lets a new byte be staged while the current frame is still on the wire. Three flags track the port's state: transmit-empty, receive-full and overrun. The transmit-empty and receive-full flags each raise a one-cycle interrupt request when they rise.

There are two enable bits, one for transmit and one for receive. With both set the port runs full duplex, and frames happen only when there is a byte to send. With only receive set, frames run back to back for as long as nothing blocks them. If a frame finishes while the previous received byte has not been taken, the port sets the overrun flag. No further frame starts in either direction until software clears that flag. The bit clock runs at `clk / (2*HALF_CYC)`.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status register (address 2) reads 0x01, the control register (address 3) reads 0x00, `sclk` and `txd` are high, and both interrupt outputs are low.
- R2: A write to the transmit holding register (address 0) is accepted only while transmit-empty (status bit 0) is 1. Otherwise the write is ignored, and the holding register keeps its value, which can be read back at address 0.
- R3: A frame carries 8 bits, least significant bit first. `txd` changes when `sclk` falls and `rxd` is taken when `sclk` rises. Each `sclk` phase lasts HALF_CYC clock cycles. Between frames `sclk` and `txd` are high.
- R4: With transmit enabled (control bit 0), clearing transmit-empty starts a frame. The held byte moves to the shifter, transmit-empty returns to 1, and `tx_irq` pulses for exactly one cycle.
- R5: With receive enabled (control bit 1), a completed frame moves its byte to the receive register (address 1) and sets receive-full (status bit 1). `rx_irq` pulses for one cycle.
- R6: If receive-full is still 1 when a frame completes, overrun (status bit 2) is set and the receive register keeps its old byte.
- R7: While overrun is 1, no frame starts in either direction, even with a byte waiting. Writing 0 to status bit 2 releases the port. In the status register, writing 0 to a bit clears it and writing 1 leaves it unchanged.
- R8: If a new byte is staged and transmit-empty is cleared before the current frame ends, the next frame follows with no idle clock. Otherwise the port idles with `sclk` and `txd` high.
- R9: A strobe on `hw_tx_we` loads `hw_tx_data` and clears transmit-empty in the same step. A strobe on `hw_rx_re` clears receive-full, and `hw_rx_data` always shows the receive register.
- R10: With only receive enabled (control = 0x02), frames run continuously and `txd` stays high.
- R11: Clearing both enables stops the bit clock at once, even mid-frame, and leaves every data register and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 tx hold, 1 rx data, 2 status, 3 control |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from `bus_addr`) |
| hw_tx_we | input | 1 | Hardware-access transmit write strobe |
| hw_tx_data | input | 8 | Hardware-access transmit byte |
| hw_rx_re | input | 1 | Hardware-access receive read strobe |
| hw_rx_data | output | 8 | Receive register contents |
| sclk | output | 1 | Generated serial clock, idle high |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| tx_irq | output | 1 | Transmit-empty rising pulse |
| rx_irq | output | 1 | Receive-full rising pulse |

## Verification
The hardest state to reach is the overrun stall while a byte is already staged for transmission. Reaching it takes two complete frames with the receive flag deliberately left set. Then a third byte must be staged, and the bench must show that the clock stays quiet. The bench gets there through the normal register window. It plays a serial peer that supplies a distinct byte per frame, indexed by its own count of falling clock edges, and it records every transmitted byte and frame start time. This also lets it measure the gap-free back-to-back case as an exact frame period between clock falls.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] A_TXH  = 2'd0;
  localparam logic [1:0] A_RXD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  localparam int unsigned ST_TXE = 0;
  localparam int unsigned ST_RXF = 1;
  localparam int unsigned ST_OVR = 2;
  localparam int unsigned CT_TXEN = 0;
  localparam int unsigned CT_RXEN = 1;

  function automatic logic [BYTE_W-1:0] shift_in_msb(input logic [BYTE_W-1:0] cur, input logic b);
    return {b, cur[BYTE_W-1:1]};
  endfunction

  function automatic logic [BYTE_W-1:0] shift_out_lsb(input logic [BYTE_W-1:0] cur);
    return {1'b1, cur[BYTE_W-1:1]};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic txe, input logic rxf, input logic ovr);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_TXE] = txe;
    s[ST_RXF] = rxf;
    s[ST_OVR] = ovr;
    return s;
  endfunction
endpackage

// File: rtl/ssp_bitclk.sv
module ssp_bitclk #(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned NBITS    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic sclk_o,
  output logic active_o,
  output logic fall_o,
  output logic rise_o,
  output logic frame_end_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned BW = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic          hi;
  logic          tick;
  logic          last_bit;

  assign tick        = (cnt == CW'(HALF_CYC - 1));
  assign last_bit    = (bitn == BW'(NBITS - 1));
  assign rise_o      = active_o && !hi && tick;
  assign frame_end_o = active_o && hi && tick && last_bit;
  assign fall_o      = start_i || (active_o && hi && tick && !last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0; sclk_o <= 1'b1; cnt <= '0; hi <= 1'b0; bitn <= '0;
    end else if (abort_i) begin
      active_o <= 1'b0; sclk_o <= 1'b1; cnt <= '0; hi <= 1'b0; bitn <= '0;
    end else if (start_i) begin
      active_o <= 1'b1; sclk_o <= 1'b0; cnt <= '0; hi <= 1'b0; bitn <= '0;
    end else if (active_o) begin
      if (tick) begin
        cnt <= '0;
        if (!hi) begin
          hi <= 1'b1; sclk_o <= 1'b1;
        end else if (last_bit) begin
          active_o <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1; hi <= 1'b0; sclk_o <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssp_tx_shift.sv
module ssp_tx_shift
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              fall_i,
  input  logic              end_i,
  output logic              txd_o
);
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1; txd_o <= 1'b1;
    end else if (clr_i) begin
      sh <= '1; txd_o <= 1'b1;
    end else if (load_i) begin
      sh <= data_i; txd_o <= data_i[0];
    end else if (fall_i) begin
      sh <= shift_out_lsb(sh); txd_o <= sh[1];
    end else if (end_i) begin
      txd_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ssp_rx_shift.sv
module ssp_rx_shift
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              rxd_i,
  output logic [BYTE_W-1:0] byte_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_o <= '0;
    else if (clr_i)  byte_o <= '0;
    else if (rise_i) byte_o <= shift_in_msb(byte_o, rxd_i);
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              hw_tx_we,
  input  logic [BYTE_W-1:0] hw_tx_data,
  input  logic              hw_rx_re,
  output logic [BYTE_W-1:0] hw_rx_data,
  output logic              sclk,
  output logic              txd,
  input  logic              rxd,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic tx_en, rx_en, txe_f, rxf_f, ovr_f, txe_d, rxf_d;
  logic [BYTE_W-1:0] tdr_q, rdr_q, rx_byte;

  // named internal events
  logic sw_tdr_wr, stat_wr, ctrl_wr, tdr_wr_any, tdr_accept;
  logic txe_clr, rxf_clr, ovr_clr, eng_abort, want_frame, start_frame;
  logic tx_load, rx_store, rxf_busy, ovr_set, rdr_load;
  logic eng_active, frame_end, bit_fall, bit_rise;

  assign sw_tdr_wr   = bus_wr && (bus_addr == A_TXH);
  assign stat_wr     = bus_wr && (bus_addr == A_STAT);
  assign ctrl_wr     = bus_wr && (bus_addr == A_CTRL);
  assign tdr_wr_any  = sw_tdr_wr || hw_tx_we;
  assign tdr_accept  = txe_f && tdr_wr_any;
  assign txe_clr     = (stat_wr && !bus_wdata[ST_TXE]) || (hw_tx_we && txe_f);
  assign rxf_clr     = (stat_wr && !bus_wdata[ST_RXF]) || hw_rx_re;
  assign ovr_clr     = stat_wr && !bus_wdata[ST_OVR];
  assign eng_abort   = !tx_en && !rx_en;
  assign rx_store    = frame_end && rx_en;
  assign rxf_busy    = rxf_f && !rxf_clr;
  assign ovr_set     = rx_store && rxf_busy;
  assign rdr_load    = rx_store && !rxf_busy;
  assign want_frame  = !ovr_f && ((tx_en && !txe_f) || (!tx_en && rx_en));
  assign start_frame = want_frame && !ovr_set && !eng_abort && (!eng_active || frame_end);
  assign tx_load     = start_frame && tx_en;

  ssp_bitclk #(.HALF_CYC(HALF_CYC), .NBITS(BYTE_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .start_i(start_frame), .abort_i(eng_abort),
    .sclk_o(sclk), .active_o(eng_active), .fall_o(bit_fall), .rise_o(bit_rise),
    .frame_end_o(frame_end)
  );

  ssp_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n), .clr_i(!tx_en), .load_i(tx_load), .data_i(tdr_q),
    .fall_i(bit_fall), .end_i(frame_end), .txd_o(txd)
  );

  ssp_rx_shift u_rx (
    .clk(clk), .rst_n(rst_n), .clr_i(!rx_en), .rise_i(bit_rise), .rxd_i(rxd),
    .byte_o(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0; rx_en <= 1'b0;
      txe_f <= 1'b1; rxf_f <= 1'b0; ovr_f <= 1'b0;
      txe_d <= 1'b1; rxf_d <= 1'b0;
      tdr_q <= '0;   rdr_q <= '0;
    end else begin
      txe_d <= txe_f;
      rxf_d <= rxf_f;
      if (ctrl_wr) begin
        tx_en <= bus_wdata[CT_TXEN];
        rx_en <= bus_wdata[CT_RXEN];
      end
      if (tdr_accept) tdr_q <= hw_tx_we ? hw_tx_data : bus_wdata;
      if (tx_load)      txe_f <= 1'b1;
      else if (txe_clr) txe_f <= 1'b0;
      if (rdr_load) begin
        rdr_q <= rx_byte; rxf_f <= 1'b1;
      end else if (rxf_clr) begin
        rxf_f <= 1'b0;
      end
      if (ovr_set)      ovr_f <= 1'b1;
      else if (ovr_clr) ovr_f <= 1'b0;
    end
  end

  assign tx_irq     = txe_f && !txe_d;
  assign rx_irq     = rxf_f && !rxf_d;
  assign hw_rx_data = rdr_q;

  always_comb begin
    unique case (bus_addr)
      A_TXH:   bus_rdata = tdr_q;
      A_RXD:   bus_rdata = rdr_q;
      A_STAT:  bus_rdata = pack_status(txe_f, rxf_f, ovr_f);
      default: bus_rdata = {{(BYTE_W-2){1'b0}}, rx_en, tx_en};
    endcase
  end
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_irq,
  input logic       rx_irq,
  input logic       txe,
  input logic       rxf,
  input logic       ovr,
  input logic       rx_en,
  input logic       eng_active,
  input logic       frame_end,
  input logic       sclk,
  input logic       txd,
  input logic       tdr_wr_any,
  input logic [7:0] tdr,
  input logic [7:0] rdr
);
  p_idle_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |-> (sclk && txd));

  p_txirq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  p_rxirq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  p_store_sets_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && rx_en && !rxf) |=> rxf);

  p_ovr_keeps_rdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(rdr));

  p_ovr_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !eng_active) |=> !eng_active);

  p_hold_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tdr_wr_any && !txe) |=> $stable(tdr));
endmodule

bind sync_serial_port ssp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .txe(txe_f), .rxf(rxf_f), .ovr(ovr_f), .rx_en(rx_en),
  .eng_active(eng_active), .frame_end(frame_end), .sclk(sclk), .txd(txd),
  .tdr_wr_any(tdr_wr_any), .tdr(tdr_q), .rdr(rdr_q)
);

// File: tb/sim_sync_serial_port.sv
`timescale 1ns/1ps
module sim_sync_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, hw_tx_we = 1'b0, hw_rx_re = 1'b0, rxd = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, hw_tx_data = 8'h00;
  logic [7:0] bus_rdata, hw_rx_data;
  logic sclk, txd, tx_irq, rx_irq;

  int n_chk = 0, n_fail = 0;
  int tx_irq_n = 0, rx_irq_n = 0;
  int cap_n = 0, nb = 0, fall_n = 0, rbit = 0;
  logic [7:0] cap = 8'h00, cur_pat = 8'h00;
  logic [7:0] txq [16];
  logic [7:0] rx_q [16];
  time fall_t [16];

  always #2 clk = ~clk;

  sync_serial_port #(.HALF_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_tx_we(hw_tx_we),
    .hw_tx_data(hw_tx_data), .hw_rx_re(hw_rx_re), .hw_rx_data(hw_rx_data),
    .sclk(sclk), .txd(txd), .rxd(rxd), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // serial peer: presents its bits on falling sclk, records frame starts
  always @(negedge sclk) if (rst_n) begin
    if (rbit == 0) begin
      cur_pat = rx_q[fall_n % 16];
      fall_t[fall_n % 16] = $time;
      fall_n++;
    end
    rxd = cur_pat[rbit];
    rbit = (rbit + 1) % 8;
  end

  // capture of the transmit line on rising sclk
  always @(posedge sclk) if (rst_n) begin
    cap = {txd, cap[7:1]};
    nb++;
    if (nb == 8) begin
      txq[cap_n % 16] = cap;
      cap_n++;
      nb = 0;
    end
  end

  always @(negedge clk) begin
    if (tx_irq) tx_irq_n++;
    if (rx_irq) rx_irq_n++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cap(input int n);
    for (int i = 0; i < 3000 && cap_n < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd2, d); chk("R1", "status", d, 8'h01);
    rd(2'd3, d); chk("R1", "control", d, 8'h00);
    chk("R1", "sclk/txd/irqs", {sclk, txd, tx_irq, rx_irq}, 4'b1100);
  endtask

  task automatic t_duplex_single();
    logic [7:0] d;
    int c0, t0, r0, f0;
    wr(2'd3, 8'h03);
    rx_q[fall_n % 16] = 8'h3C;
    c0 = cap_n; t0 = tx_irq_n; r0 = rx_irq_n;
    wr(2'd0, 8'hA5);
    wr(2'd2, 8'h06);
    wait_cap(c0 + 1);
    chk("R3", "sent byte", txq[c0 % 16], 8'hA5);
    rd(2'd1, d); chk("R5", "received byte", d, 8'h3C);
    rd(2'd2, d); chk("R4", "status after frame", d, 8'h03);
    chk("R4", "tx_irq pulses", tx_irq_n - t0, 1);
    chk("R5", "rx_irq pulses", rx_irq_n - r0, 1);
    f0 = fall_n;
    repeat (40) @(negedge clk);
    chk("R8", "idle: no new frame", fall_n - f0, 0);
    chk("R8", "idle lines", {sclk, txd}, 2'b11);
    wr(2'd2, 8'h05);
  endtask

  task automatic t_write_guard();
    logic [7:0] d;
    int c0;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h11);
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h22);
    rd(2'd0, d); chk("R2", "hold reg keeps first byte", d, 8'h11);
    rd(2'd2, d); chk("R2", "txe still clear", d, 8'h00);
    c0 = cap_n;
    wr(2'd3, 8'h01);
    wait_cap(c0 + 1);
    chk("R2", "tx-only frame sends accepted byte", txq[c0 % 16], 8'h11);
    rd(2'd2, d); chk("R4", "tx-only: no receive", d, 8'h01);
  endtask

  task automatic t_back_to_back();
    logic [7:0] d;
    int c0, f0;
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h03);
    f0 = fall_n; c0 = cap_n;
    rx_q[f0 % 16] = 8'h81;
    rx_q[(f0 + 1) % 16] = 8'h7E;
    wr(2'd0, 8'hC3);
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h3C);
    wr(2'd2, 8'h06);
    for (int i = 0; i < 3000 && cap_n < c0 + 1; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk("R5", "first back-to-back rx", d, 8'h81);
    wr(2'd2, 8'h05);
    wait_cap(c0 + 2);
    chk("R8", "first byte", txq[c0 % 16], 8'hC3);
    chk("R8", "second byte", txq[(c0 + 1) % 16], 8'h3C);
    chk("R8", "frame spacing ns", int'(fall_t[(f0 + 1) % 16] - fall_t[f0 % 16]), 128);
    rd(2'd1, d); chk("R5", "second back-to-back rx", d, 8'h7E);
    rd(2'd2, d); chk("R6", "no overrun when serviced", d, 8'h03);
    wr(2'd2, 8'h05);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    int c0, f0;
    wr(2'd2, 8'h01);
    f0 = fall_n; c0 = cap_n;
    rx_q[f0 % 16] = 8'h55;
    rx_q[(f0 + 1) % 16] = 8'hAA;
    rx_q[(f0 + 2) % 16] = 8'h99;
    wr(2'd0, 8'h01); wr(2'd2, 8'h06);
    wait_cap(c0 + 1);
    wr(2'd0, 8'h02); wr(2'd2, 8'h06);
    wait_cap(c0 + 2);
    rd(2'd2, d); chk("R6", "overrun status", d, 8'h07);
    rd(2'd1, d); chk("R6", "rx register kept", d, 8'h55);
    wr(2'd0, 8'h03); wr(2'd2, 8'h06);
    repeat (200) @(negedge clk);
    chk("R7", "no frame while overrun", cap_n - c0, 2);
    rd(2'd2, d); chk("R7", "byte still waiting", d, 8'h06);
    wr(2'd2, 8'h00);
    wait_cap(c0 + 3);
    chk("R7", "frame after release", txq[(c0 + 2) % 16], 8'h03);
    rd(2'd1, d); chk("R7", "rx after release", d, 8'h99);
    rd(2'd2, d); chk("R7", "status after release", d, 8'h03);
  endtask

  task automatic t_hw_path();
    logic [7:0] d;
    int c0, t0;
    wr(2'd2, 8'h05);
    rx_q[fall_n % 16] = 8'h6B;
    c0 = cap_n; t0 = tx_irq_n;
    @(negedge clk); hw_tx_we = 1'b1; hw_tx_data = 8'h5A;
    @(negedge clk); hw_tx_we = 1'b0;
    wait_cap(c0 + 1);
    chk("R9", "hw byte sent", txq[c0 % 16], 8'h5A);
    chk("R9", "tx_irq from hw write", tx_irq_n - t0, 1);
    chk("R9", "hw rx data", hw_rx_data, 8'h6B);
    @(negedge clk); hw_rx_re = 1'b1;
    @(negedge clk); hw_rx_re = 1'b0;
    rd(2'd2, d); chk("R9", "hw read clears rxf", d, 8'h01);
  endtask

  task automatic t_rx_only();
    logic [7:0] d;
    int c0, f0;
    wr(2'd3, 8'h00);
    f0 = fall_n; c0 = cap_n;
    rx_q[f0 % 16] = 8'hE1;
    rx_q[(f0 + 1) % 16] = 8'h1E;
    wr(2'd3, 8'h02);
    wait_cap(c0 + 1);
    rd(2'd1, d); chk("R10", "rx-only first byte", d, 8'hE1);
    chk("R10", "txd idle during rx-only", txq[c0 % 16], 8'hFF);
    wr(2'd2, 8'h05);
    wait_cap(c0 + 2);
    rd(2'd1, d); chk("R10", "rx-only second byte", d, 8'h1E);
    wr(2'd3, 8'h00);
    f0 = fall_n;
    repeat (100) @(negedge clk);
    chk("R11", "clock stopped", {sclk, 31'(fall_n - f0)}, {1'b1, 31'd0});
    rd(2'd1, d); chk("R11", "rx register untouched", d, 8'h1E);
    rd(2'd2, d); chk("R11", "flags untouched", d, 8'h03);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 16; i++) begin rx_q[i] = 8'h00; txq[i] = 8'h00; fall_t[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_duplex_single();
    t_write_guard();
    t_back_to_back();
    t_overrun();
    t_hw_path();
    t_rx_only();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule